// File: doc/BRIEF.md
# Daily Self-Latching Valve Timer

This block times one watering period for a valve. After power-up or a push-button reset it opens the valve and runs a binary timer: a prescaler selected by a two-bit tap code feeds a chain of counter stages. When the carry reaches the top stage, the block latches itself. Counting stops, the valve closes, and the block stays in that state until the next reset.

There are two valve drive modes. In steady mode the valve stays open for the whole period. In pulsed mode the valve follows an inverted low counter stage, so it opens and closes in turn while the period runs. Two lamp outputs show whether the block is still timing or has finished.

A two-state machine holds the period. `ST_RUN` is entered by reset and drives the running lamp and the valve. It takes the transition *finish* to `ST_HALT` on the tick whose carry enters the top stage. `ST_HALT` has only one transition, *restart*, which is reset back to `ST_RUN`.

Top module: `valve_day_timer`

## Requirements
- R1: While reset is asserted and right after it is released, the stage counter is zero, `lamp_run` is 1, `lamp_done` is 0 and `valve_on` is 1.
- R2: With tap code `t` (0..3), one counter tick occurs every 2^(DIV_BASE_LOG2 + t*DIV_STEP_LOG2) clock cycles. The first tick comes at the end of that many cycles after reset release. The period ends on the clock edge of tick number 2^(STAGES-1).
- R3: With `mode_pulse` = 0, `valve_on` is 1 on every cycle of the period.
- R4: Once the top stage is set, the counter no longer advances, and the machine is in `ST_HALT` exactly when the top stage is set.
- R5: From the end of the period until reset, `lamp_done` = 1 and `valve_on` = 0.
- R6: With `mode_pulse` = 1, `valve_on` equals NOT counter bit PULSE_BIT while the period runs, so the valve starts open.
- R7: Exactly one of `lamp_run` and `lamp_done` is 1 at any time.
- R8: Asserting reset at any point of the period restarts the cycle from the R1 state.
- R9: After the end of the period, changes on `tap_sel` and `mode_pulse` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on or push-button) |
| tap_sel | input | 2 | Delay setting, selects the prescaler ratio |
| mode_pulse | input | 1 | 0: steady valve drive, 1: pulsed valve drive |
| valve_on | output | 1 | Valve drive, 1 = open |
| lamp_run | output | 1 | 1 while the period runs |
| lamp_done | output | 1 | 1 once the period has ended |

## Verification
The bench builds the block with STAGES=4, DIV_BASE_LOG2=0, DIV_STEP_LOG2=1 and PULSE_BIT=0. The four tap codes then give tick spacings of 1, 2, 4 and 8 cycles, and every period ends within 64 cycles. This makes it practical to check every cycle of every tap and mode pair against an arithmetic model. With these values the pulsed valve toggles on each tick, so every tick edge can be seen at the valve output. The bench also covers the last pulsed step before the latch, a reset partway through a period, and input changes after the latch.

// File: rtl/vt_pkg.sv
package vt_pkg;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } vt_state_e;

    // log2 of the prescaler ratio for a given tap code
    function automatic int ratio_log2(input logic [1:0] tap, input int base, input int step);
        return base + int'(tap) * step;
    endfunction

endpackage

// File: rtl/vt_prescaler.sv
module vt_prescaler #(
    parameter int DIV_BASE_LOG2 = 4,
    parameter int DIV_STEP_LOG2 = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] tap_sel,
    output logic       tick
);
    import vt_pkg::*;

    localparam int MAX_LOG2 = DIV_BASE_LOG2 + 3 * DIV_STEP_LOG2;
    localparam int PRE_W    = (MAX_LOG2 < 1) ? 1 : MAX_LOG2;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] low_mask;
    int               shift_amt;

    always_comb begin
        shift_amt = ratio_log2(tap_sel, DIV_BASE_LOG2, DIV_STEP_LOG2);
        low_mask  = (PRE_W'(1) << shift_amt) - PRE_W'(1);
        tick      = run & (&(pre_q | ~low_mask));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    // R2: the prescaler only moves while the period runs
    prescale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(pre_q));

endmodule

// File: rtl/vt_stage_counter.sv
module vt_stage_counter #(
    parameter int STAGES = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              hold,
    output logic [STAGES-1:0] stage_q,
    output logic              carry_top
);
    logic [STAGES-1:0] carry;

    // ripple carry chain, one link per stage
    assign carry[0] = tick & ~hold;
    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_chain
            assign carry[g] = carry[g-1] & stage_q[g-1];
        end
    endgenerate

    assign carry_top = carry[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_q ^ carry;
        end
    end

    // R4: a held counter never changes
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(stage_q));

endmodule

// File: rtl/vt_ctrl_fsm.sv
module vt_ctrl_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic carry_top,
    input  logic mode_pulse,
    input  logic pulse_stage,
    output vt_pkg::vt_state_e state_q,
    output logic valve_on,
    output logic lamp_run,
    output logic lamp_done
);
    import vt_pkg::*;

    vt_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (carry_top) state_d = ST_HALT;   // finish
            ST_HALT: state_d = ST_HALT;                  // left only by reset
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        valve_on  = 1'b0;
        lamp_run  = 1'b0;
        lamp_done = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                lamp_run = 1'b1;
                valve_on = mode_pulse ? ~pulse_stage : 1'b1;
            end
            ST_HALT: begin
                lamp_done = 1'b1;
            end
            default: begin
                lamp_run = 1'b1;
            end
        endcase
    end

    // R5
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HALT |=> state_q == ST_HALT);

    // R5
    valve_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lamp_done |-> !valve_on);

endmodule

// File: rtl/valve_day_timer.sv
module valve_day_timer #(
    parameter int STAGES        = 14,
    parameter int DIV_BASE_LOG2 = 4,
    parameter int DIV_STEP_LOG2 = 2,
    parameter int PULSE_BIT     = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] tap_sel,
    input  logic       mode_pulse,
    output logic       valve_on,
    output logic       lamp_run,
    output logic       lamp_done
);
    import vt_pkg::*;

    localparam int TOP = STAGES - 1;

    logic              tick;
    logic              carry_top;
    logic [STAGES-1:0] stage_q;
    vt_state_e         state_q;
    logic              halted;

    assign halted = (state_q == ST_HALT);

    vt_prescaler #(
        .DIV_BASE_LOG2 (DIV_BASE_LOG2),
        .DIV_STEP_LOG2 (DIV_STEP_LOG2)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (!halted),
        .tap_sel (tap_sel),
        .tick    (tick)
    );

    vt_stage_counter #(
        .STAGES (STAGES)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .hold      (halted),
        .stage_q   (stage_q),
        .carry_top (carry_top)
    );

    vt_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .carry_top   (carry_top),
        .mode_pulse  (mode_pulse),
        .pulse_stage (stage_q[PULSE_BIT]),
        .state_q     (state_q),
        .valve_on    (valve_on),
        .lamp_run    (lamp_run),
        .lamp_done   (lamp_done)
    );

    // R4
    top_stage_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stage_q[TOP] == halted);

    // R7
    lamp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({lamp_run, lamp_done}));

    // R3
    steady_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lamp_run && !mode_pulse) |-> valve_on);

endmodule

// File: tb/valve_day_timer_tb_top.sv
`timescale 1ns/1ps
module valve_day_timer_tb_top;

    localparam int STAGES = 4;
    localparam int BASE   = 0;
    localparam int STEP   = 1;
    localparam int PBIT   = 0;
    localparam int LAST   = 1 << (STAGES - 1);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] tap_sel = 2'd0;
    logic       mode_pulse = 1'b0;
    logic       valve_on, lamp_run, lamp_done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    valve_day_timer #(
        .STAGES (STAGES), .DIV_BASE_LOG2 (BASE),
        .DIV_STEP_LOG2 (STEP), .PULSE_BIT (PBIT)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .tap_sel (tap_sel), .mode_pulse (mode_pulse),
        .valve_on (valve_on), .lamp_run (lamp_run), .lamp_done (lamp_done)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    // compare all outputs with the model after e edges since release
    task automatic check_model(input int e, input int k, input logic pm);
        int  ticks = e >> k;
        int  cnt   = (ticks > LAST) ? LAST : ticks;
        bit  done  = (ticks >= LAST);
        logic exp_v = !done && (!pm || !cnt[PBIT]);
        if (e == 0) begin
            check("R1 valve", valve_on, 1'b1);
            check("R1 lamp_run", lamp_run, 1'b1);
            check("R1 lamp_done", lamp_done, 1'b0);
        end else begin
            check(done ? (e == (LAST << k) ? "R2 end" : "R4/R5 held") : (pm ? "R6 valve" : "R3 valve"),
                  valve_on, exp_v);
            check(e == (LAST << k) ? "R2 done edge" : "R5 lamp_done", lamp_done, done);
            check("R7 lamp_run", lamp_run, !done);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R8 valve in reset", valve_on, 1'b1);
        check("R8 lamp_run in reset", lamp_run, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        for (int t = 0; t < 4; t++) begin
            for (int m = 0; m < 2; m++) begin
                tap_sel = 2'(t);
                mode_pulse = 1'(m);
                do_reset();
                check_model(0, BASE + t * STEP, 1'(m));
                for (int e = 1; e <= (LAST << (BASE + t * STEP)) + 6; e++) begin
                    @(negedge clk);
                    check_model(e, BASE + t * STEP, 1'(m));
                end
            end
        end

        // R8: reset partway through a period, then a full clean run
        tap_sel = 2'd1;
        mode_pulse = 1'b1;
        do_reset();
        repeat (5) @(negedge clk);
        do_reset();
        check_model(0, 1, 1'b1);
        for (int e = 1; e <= (LAST << 1) + 2; e++) begin
            @(negedge clk);
            check_model(e, 1, 1'b1);
        end

        // R9: after the latch, input changes do nothing
        for (int i = 0; i < 8; i++) begin
            tap_sel = 2'(i % 4);
            mode_pulse = 1'(i % 2);
            @(negedge clk);
            check("R9 valve", valve_on, 1'b0);
            check("R9 lamp_done", lamp_done, 1'b1);
            check("R9 lamp_run", lamp_run, 1'b0);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule